// File: doc/BRIEF.md
# DAC Waveform Table Sequencer

This block plays back a short table of DAC codes to build a periodic or one-shot waveform on a single DAC channel. The host loads up to sixteen 12-bit words through a write port while playback is switched off. It then writes a configuration word that turns playback on and picks how the table is used. Every step strobe moves the output code on by one table word. The host interface that decodes the serial command raises the strobe on the last clock edge of that command. The 8 data bits of the command are never passed into the block.

Three mode bits set how the stored words become a waveform. With mirroring on, a reverse pass follows the forward pass, so a quarter or half period stored once gives a symmetric shape. With signed mode on, each word is sign-magnitude: bit 11 is the sign and bits 10:0 are the magnitude. The output is then offset-binary around mid-scale. If mirroring is also on, a third and fourth pass replay the table with the sign inverted. The looping bit picks between endless repetition and a single run that stops on the last code. The first step after any configuration write sends the separately held input-register code to the output. This gives the waveform a defined starting level.

Top module: `wfs_seq`

## Requirements
- R1: After reset the output code is 0, `seq_done` is 0, playback is off, every table word reads 0 and the length field is all ones (all 16 words used).
- R2: A table write takes effect only while playback is off. A write made while playback is on leaves the stored word unchanged. `tbl_rdata` shows the word at `tbl_raddr` at all times, one cycle after any accepted write.
- R3: A configuration write returns the sequence to its start and clears `seq_done`, even in the middle of a run. A step in the same cycle as a configuration write is ignored.
- R4: With playback on, the first step after a configuration write puts the input-register value on `dac_code`.
- R5: Each later step outputs the next word. The length field L selects words 0..L, so L=15 uses all 16. The forward pass plays addresses 0 up to L.
- R6: With mirroring on, the forward pass is followed by a reverse pass over addresses L down to 0, with both end words repeated at the turn.
- R7: With signed mode on, a word with sign bit 11 clear and magnitude m gives 2048+m, and with the sign set gives 2048-m. The result is limited to 1..4095. With mirroring also on, passes three (forward) and four (reverse) use the opposite sign.
- R8: With looping on, the step after the last pass restarts at address 0 of the first pass. With looping off, `seq_done` rises after the last word and later steps leave `dac_code` unchanged.
- R9: A step while playback is off leaves `dac_code` unchanged.
- R10: `dac_code` changes only on the clock edge that samples a step, and is stable in every cycle without a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Playback on |
| cfg_signed | input | 1 | Sign-magnitude table words |
| cfg_mirror | input | 1 | Add a reverse pass |
| cfg_loop | input | 1 | Repeat endlessly |
| cfg_len | input | 4 | Index of the last used word |
| tbl_wr | input | 1 | Table write strobe |
| tbl_waddr | input | 4 | Table write address |
| tbl_wdata | input | 12 | Table write data |
| tbl_raddr | input | 4 | Table read address |
| tbl_rdata | output | 12 | Table read data |
| in_wr | input | 1 | Input-register write strobe |
| in_data | input | 12 | Input-register value |
| step | input | 1 | Sequence step strobe |
| dac_code | output | 12 | DAC output-register code |
| seq_done | output | 1 | Single run finished |

## Verification
Every step result shows on `dac_code` after exactly one register. The bench raises the strobe at a falling edge and reads the code at the next falling edge, half a cycle after the edge that captured it. Table writes and configuration writes are also registered once. A read-back or a following step is therefore issued only after the falling edge after the write's capture edge. The stall checks hold the strobe low for several cycles and compare the code at each falling edge.

// File: rtl/wfs_pkg.sv
`timescale 1ns/1ps
package wfs_pkg;

    typedef enum logic [1:0] {
        PH_FWD     = 2'd0,
        PH_REV     = 2'd1,
        PH_FWD_NEG = 2'd2,
        PH_REV_NEG = 2'd3
    } wfs_phase_e;

    typedef struct packed {
        logic enable;
        logic signed_on;
        logic mirror;
        logic loop_on;
    } wfs_mode_t;

    function automatic wfs_phase_e wfs_final_phase(input logic mirror, input logic signed_on);
        if (!mirror)        return PH_FWD;
        else if (signed_on) return PH_REV_NEG;
        else                return PH_REV;
    endfunction

    function automatic logic wfs_is_reverse(input wfs_phase_e ph);
        return (ph == PH_REV) || (ph == PH_REV_NEG);
    endfunction

    function automatic logic wfs_is_negated(input wfs_phase_e ph);
        return (ph == PH_FWD_NEG) || (ph == PH_REV_NEG);
    endfunction

endpackage

// File: rtl/wfs_table.sv
`timescale 1ns/1ps
module wfs_table #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             locked,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    host_raddr,
    output logic [WIDTH-1:0] host_rdata,
    input  logic [AW-1:0]    play_raddr,
    output logic [WIDTH-1:0] play_rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && !locked && (waddr == AW'(i))) begin
                mem_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign host_rdata = mem_q[host_raddr];
    assign play_rdata = mem_q[play_raddr];

    // R2: a write while playback runs must not disturb the stored word
    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked) |=> (mem_q[$past(waddr)] == $past(mem_q[waddr])));

    // R2: an accepted write lands on the addressed word
    p_open_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked) |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/wfs_stepper.sv
`timescale 1ns/1ps
module wfs_stepper
    import wfs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          enable,
    input  logic          step,
    input  logic          mirror,
    input  logic          signed_on,
    input  logic          loop_on,
    input  logic [AW-1:0] last,
    output logic          load_o,
    output logic          fire_o,
    output wfs_phase_e    phase_o,
    output logic [AW-1:0] addr_o,
    output logic          done_o
);
    typedef struct packed {
        logic          armed;
        logic          done;
        wfs_phase_e    phase;
        logic [AW-1:0] pos;
    } step_state_t;

    step_state_t st_d, st_q;
    wfs_phase_e  final_ph;
    logic        go;

    always_comb begin
        st_d     = st_q;
        final_ph = wfs_final_phase(mirror, signed_on);
        go       = enable && step && !restart;
        load_o   = go && st_q.armed;
        fire_o   = go && !st_q.armed && !st_q.done;

        if (restart) begin
            st_d.armed = 1'b1;
            st_d.done  = 1'b0;
            st_d.phase = PH_FWD;
            st_d.pos   = '0;
        end else if (load_o) begin
            st_d.armed = 1'b0;
        end else if (fire_o) begin
            if (st_q.pos == last) begin
                st_d.pos = '0;
                if (st_q.phase == final_ph) begin
                    if (loop_on) st_d.phase = PH_FWD;
                    else         st_d.done  = 1'b1;
                end else begin
                    st_d.phase = wfs_phase_e'(st_q.phase + 2'd1);
                end
            end else begin
                st_d.pos = st_q.pos + AW'(1);
            end
        end

        addr_o  = wfs_is_reverse(st_q.phase) ? (last - st_q.pos) : st_q.pos;
        phase_o = st_q.phase;
        done_o  = st_q.done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.done  <= 1'b0;
            st_q.phase <= PH_FWD;
            st_q.pos   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a configuration write re-arms the start and clears completion
    p_restart_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.armed && !st_q.done && st_q.phase == PH_FWD));

    // R8: completion of a single run persists until the next configuration write
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !restart) |=> st_q.done);

    // R6: no reverse or inverted pass without mirroring
    p_phase_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mirror |-> (st_q.phase == PH_FWD));

    // R7: inverted passes only exist in signed mode
    p_neg_needs_signed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !signed_on |-> !wfs_is_negated(st_q.phase));

    // R5: the position never passes the last used word
    p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= last);

endmodule

// File: rtl/wfs_code.sv
`timescale 1ns/1ps
module wfs_code #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] entry,
    input  logic             signed_on,
    input  logic             negate,
    output logic [WIDTH-1:0] code
);
    localparam int MID = 1 << (WIDTH - 1);
    localparam int TOP = (1 << WIDTH) - 1;

    logic [WIDTH-2:0] mag;
    logic             sgn;
    logic [WIDTH:0]   biased;

    always_comb begin
        mag    = entry[WIDTH-2:0];
        sgn    = entry[WIDTH-1] ^ negate;
        biased = sgn ? ((WIDTH+1)'(MID) - {2'b00, mag})
                     : ((WIDTH+1)'(MID) + {2'b00, mag});
        if (!signed_on) begin
            code = entry;
        end else if (biased < (WIDTH+1)'(1)) begin
            code = WIDTH'(1);
        end else if (biased > (WIDTH+1)'(TOP)) begin
            code = WIDTH'(TOP);
        end else begin
            code = biased[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/wfs_seq.sv
`timescale 1ns/1ps
module wfs_seq
    import wfs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_enable,
    input  logic             cfg_signed,
    input  logic             cfg_mirror,
    input  logic             cfg_loop,
    input  logic [AW-1:0]    cfg_len,
    input  logic             tbl_wr,
    input  logic [AW-1:0]    tbl_waddr,
    input  logic [WIDTH-1:0] tbl_wdata,
    input  logic [AW-1:0]    tbl_raddr,
    output logic [WIDTH-1:0] tbl_rdata,
    input  logic             in_wr,
    input  logic [WIDTH-1:0] in_data,
    input  logic             step,
    output logic [WIDTH-1:0] dac_code,
    output logic             seq_done
);
    typedef struct packed {
        wfs_mode_t        mode;
        logic [AW-1:0]    last;
        logic [WIDTH-1:0] in_reg;
        logic [WIDTH-1:0] out;
    } top_state_t;

    top_state_t s_d, s_q;

    logic             load_w, fire_w;
    wfs_phase_e       phase_w;
    logic [AW-1:0]    play_addr_w;
    logic [WIDTH-1:0] play_word_w;
    logic [WIDTH-1:0] code_w;

    wfs_table #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr),
        .locked     (s_q.mode.enable),
        .waddr      (tbl_waddr),
        .wdata      (tbl_wdata),
        .host_raddr (tbl_raddr),
        .host_rdata (tbl_rdata),
        .play_raddr (play_addr_w),
        .play_rdata (play_word_w)
    );

    wfs_stepper #(.DEPTH(DEPTH)) u_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cfg_wr),
        .enable    (s_q.mode.enable),
        .step      (step),
        .mirror    (s_q.mode.mirror),
        .signed_on (s_q.mode.signed_on),
        .loop_on   (s_q.mode.loop_on),
        .last      (s_q.last),
        .load_o    (load_w),
        .fire_o    (fire_w),
        .phase_o   (phase_w),
        .addr_o    (play_addr_w),
        .done_o    (seq_done)
    );

    wfs_code #(.WIDTH(WIDTH)) u_code (
        .entry     (play_word_w),
        .signed_on (s_q.mode.signed_on),
        .negate    (wfs_is_negated(phase_w)),
        .code      (code_w)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_wr) begin
            s_d.mode.enable    = cfg_enable;
            s_d.mode.signed_on = cfg_signed;
            s_d.mode.mirror    = cfg_mirror;
            s_d.mode.loop_on   = cfg_loop;
            s_d.last           = cfg_len;
        end
        if (in_wr) begin
            s_d.in_reg = in_data;
        end
        if (load_w) begin
            s_d.out = s_q.in_reg;
        end else if (fire_w) begin
            s_d.out = code_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode   <= '0;
            s_q.last   <= '1;
            s_q.in_reg <= '0;
            s_q.out    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dac_code = s_q.out;

    // R10: without a step the output code holds
    p_hold_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> (dac_code == $past(dac_code)));

    // R9: a step with playback off changes nothing
    p_idle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !s_q.mode.enable) |=> $stable(dac_code));

    // R7: signed playback never reaches code zero
    p_signed_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_w && s_q.mode.signed_on) |=> (dac_code != '0));

    // R4: the arming step hands over the input register
    p_arm_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_w && !in_wr) |=> (dac_code == $past(s_q.in_reg)));

endmodule

// File: tb/wfs_seq_bench.sv
`timescale 1ns/1ps
module wfs_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_enable = 0, cfg_signed = 0, cfg_mirror = 0, cfg_loop = 0;
    logic [3:0]  cfg_len = '0;
    logic        tbl_wr = 0;
    logic [3:0]  tbl_waddr = '0, tbl_raddr = '0;
    logic [11:0] tbl_wdata = '0, in_data = '0;
    logic [11:0] tbl_rdata, dac_code;
    logic        in_wr = 0, step = 0, seq_done;

    int checks = 0;
    int errors = 0;
    int shadow [16];

    always #2 clk = ~clk;

    wfs_seq u_wfs_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_signed(cfg_signed),
        .cfg_mirror(cfg_mirror), .cfg_loop(cfg_loop), .cfg_len(cfg_len),
        .tbl_wr(tbl_wr), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata),
        .in_wr(in_wr), .in_data(in_data), .step(step),
        .dac_code(dac_code), .seq_done(seq_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_cfg(input bit en, input bit sg, input bit mi, input bit lp, input int len);
        @(negedge clk);
        cfg_wr = 1; cfg_enable = en; cfg_signed = sg; cfg_mirror = mi; cfg_loop = lp;
        cfg_len = 4'(len);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic put_tbl(input int a, input int v);
        @(negedge clk);
        tbl_wr = 1; tbl_waddr = 4'(a); tbl_wdata = 12'(v);
        @(negedge clk);
        tbl_wr = 0;
    endtask

    task automatic put_in(input int v);
        @(negedge clk);
        in_wr = 1; in_data = 12'(v);
        @(negedge clk);
        in_wr = 0;
    endtask

    task automatic do_step();
        @(negedge clk);
        step = 1;
        @(negedge clk);
        step = 0;
    endtask

    function automatic int smap(input int e, input bit neg);
        int m = e & 2047;
        bit s = ((e >> 11) & 1) != 0;
        s = s ^ neg;
        return s ? 2048 - m : 2048 + m;
    endfunction

    task automatic load_table(input bit sg);
        for (int k = 0; k < 16; k++) begin
            int v;
            if (sg) v = (((k % 3) == 1) ? 2048 : 0) + ((k == 15) ? 2047 : k * 131);
            else    v = 100 * k + 7;
            shadow[k] = v;
            put_tbl(k, v);
        end
    endtask

    task automatic run_seq(input int len, input bit sg, input bit mi, input bit lp,
                           input int periods, input int din);
        int n = len + 1;
        int nph = mi ? (sg ? 4 : 2) : 1;
        string tag = sg ? "R7" : (mi ? "R6" : "R5");
        int last_exp = din;
        put_in(din);
        put_cfg(1, sg, mi, lp, len);
        do_step();
        check("R4 arm load", dac_code, din);
        for (int per = 0; per < periods; per++) begin
            for (int p = 0; p < nph; p++) begin
                for (int k = 0; k < n; k++) begin
                    int a = (p % 2 == 1) ? (n - 1 - k) : k;
                    int e = sg ? smap(shadow[a], p >= 2) : shadow[a];
                    do_step();
                    check(tag, dac_code, e);
                    last_exp = e;
                end
            end
        end
        if (lp) begin
            check("R8 no done in loop", seq_done, 0);
            do_step();
            check("R8 wrap", dac_code, sg ? smap(shadow[0], 0) : shadow[0]);
        end else begin
            check("R8 done", seq_done, 1);
            do_step();
            check("R8 hold after end", dac_code, last_exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 code", dac_code, 0);
        check("R1 done", seq_done, 0);
        tbl_raddr = 4'd9;
        #0;
        check("R1 table", tbl_rdata, 0);
        do_step();
        check("R1 R9 idle step", dac_code, 0);

        // R5 unipolar forward sweeps over several lengths
        load_table(0);
        foreach (shadow[k]) begin
            tbl_raddr = 4'(k);
            #1;
            check("R2 readback", tbl_rdata, shadow[k]);
        end
        run_seq(0, 0, 0, 0, 1, 12'h5A5);
        run_seq(3, 0, 0, 0, 1, 77);
        run_seq(15, 0, 0, 0, 1, 4000);
        // R6 mirrored
        run_seq(4, 0, 1, 0, 1, 1);
        run_seq(15, 0, 1, 1, 2, 9);

        // R2 locked write while playing, read still allowed
        put_tbl(5, 12'h123);
        tbl_raddr = 4'd5;
        #1;
        check("R2 locked write", tbl_rdata, shadow[5]);

        // R3 restart mid-run
        put_in(333);
        put_cfg(1, 0, 0, 0, 7);
        do_step(); do_step(); do_step();
        check("R3 mid", dac_code, shadow[1]);
        put_cfg(1, 0, 0, 0, 7);
        check("R3 no change on cfg", dac_code, shadow[1]);
        do_step();
        check("R3 restart arms", dac_code, 333);
        do_step();
        check("R3 first word", dac_code, shadow[0]);
        // R3 step coincident with cfg write is ignored
        @(negedge clk);
        cfg_wr = 1; step = 1;
        @(negedge clk);
        cfg_wr = 0; step = 0;
        check("R3 same-cycle step", dac_code, shadow[0]);
        do_step();
        check("R3 arm after same-cycle", dac_code, 333);

        // R10 stable without step
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R10 stable", dac_code, 333);
        end

        // R9 disabled step
        put_cfg(0, 0, 0, 0, 15);
        do_step();
        check("R9 disabled step", dac_code, 333);

        // R2 unlocked write lands
        put_tbl(5, 12'h123);
        shadow[5] = 12'h123;
        tbl_raddr = 4'd5;
        #1;
        check("R2 open write", tbl_rdata, 12'h123);

        // R7 signed sweeps
        load_table(1);
        run_seq(15, 1, 0, 0, 1, 2048);
        run_seq(15, 1, 1, 0, 1, 2048);
        run_seq(2, 1, 1, 1, 3, 100);
        run_seq(0, 1, 1, 0, 1, 50);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule